// File: doc/BRIEF.md
# System Configuration Register Controller

This block is a small memory-mapped control unit on a 32-bit register bus with a 4 KB window of little-endian word registers. It holds two board registers. The first drives a row of active-high indicator lights. The second shows the lock state of eight locked loops, holds a software-writable mask that picks which loops count, and gives a one-bit summary that is 1 when every picked loop is locked.

It also runs an indirect configuration channel into a small array of oscillator-frequency words. Software first writes a word into the outgoing data register. It then writes a control word that names a function code and a device index, selects read or write, and sets a start bit. The transaction completes at the clock edge that takes the control write. A selector that is not valid raises an error flag instead of faulting the bus. The result sits in a status register, and read data comes back in a return register.

The status register is the output of a three-state machine. CH_CLEAR means nothing is pending and status reads 0. CH_OK means the last transaction finished cleanly and status reads done. CH_FAULT means the last transaction had a bad selector and status reads done and error. Only a control write moves the machine. Without the start bit it goes to CH_CLEAR. With the start bit and a valid selector it goes to CH_OK. With the start bit and a bad selector it goes to CH_FAULT. Any other cycle keeps the current state. The bus read port is combinational over the registers, so any update appears on it in the cycle after the write that caused it.

Top module: `sys_cfg_ctrl`

## Requirements
- R1: After reset the control register reads 0x0010_0000, status reads 0, the light register and lock mask read 0, and oscillator entry i holds the i-th 32-bit slice of the OSC_RESET parameter.
- R2: A write to the control register (offset 0xA8) stores the word with bit 31 and bits 29:26 and 19:12 forced to 0, so a later read returns the stored value; the device index is bits 11:0, the function code bits 25:20 and the write select bit 30.
- R3: Any control write clears status (offset 0xAC, done = bit 0, error = bit 1); a write with bit 31 at 0 leaves status at 0.
- R4: A control write with bit 31 = 1, bit 30 = 1, function code 1 and device index below NUM_OSC copies the outgoing data register (offset 0xA4) into that oscillator entry and sets status to done only (0x1).
- R5: A control write with bit 31 = 1, bit 30 = 0, function code 1 and device index below NUM_OSC copies that oscillator entry into the return data register (offset 0xA0) and sets status to 0x1.
- R6: A started transaction whose function code is not 1, or whose device index is NUM_OSC or more, sets status to 0x3 and leaves the oscillator array and the return data register unchanged.
- R7: Status and return data show their new values on the read port in the cycle right after the clock edge that took the started control write.
- R8: The light register (offset 0x000) keeps write-data bits NUM_LEDS-1:0, each of which drives one active-high light output; a read returns those bits, with 0 above them.
- R9: The lock register (offset 0x004) reads the mask in bits 31:24 (the only writable bits), the live lock inputs in bits 23:16, and in bit 0 a 1 when every loop whose mask bit is 1 is locked; all other bits read 0.
- R10: Reads from any other address, including unaligned ones, return 0, and writes to them or to the read-only return and status registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lock_status | input | 8 | Per-loop locked flags |
| led_out | output | NUM_LEDS | Active-high light drives |

## Verification
The hardest case to reach from the ports is a rejected transaction that leaves state untouched. Its only signs are the error bit and values that did not change. To show it, the stimulus first puts known, distinct contents into the return register and several oscillator entries. It then issues bad-function and out-of-range-device transactions, including an index just past the array, with fresh data waiting in the outgoing register. Finally it reads every affected entry back through valid read transactions, to show that nothing was written and that no index aliased onto another entry.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LOOP_N = 8;

    // register offsets inside the 4 KB window
    localparam logic [ADDR_W-1:0] OFF_LIGHT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_RTN   = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFF_OUT   = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h0AC;

    // control word layout
    localparam int unsigned DEV_LSB   = 0;
    localparam int unsigned DEV_W     = 12;
    localparam int unsigned FUNC_LSB  = 20;
    localparam int unsigned FUNC_W    = 6;
    localparam int unsigned WSEL_BIT  = 30;
    localparam int unsigned START_BIT = 31;

    localparam logic [FUNC_W-1:0] FUNC_OSC   = 6'd1;
    localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0010_0000;
    // keeps device, function and write select; drops reserved and start
    localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;

    typedef enum logic [1:0] {
        CH_CLEAR = 2'd0,
        CH_OK    = 2'd1,
        CH_FAULT = 2'd2
    } chan_state_e;

endpackage

// File: rtl/cfg_channel.sv
module cfg_channel
    import sys_cfg_pkg::*;
#(
    parameter int unsigned            NUM_OSC   = 4,
    parameter logic [NUM_OSC*32-1:0]  OSC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              out_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] rtn_q,
    output logic [1:0]        stat
);

    localparam logic [DEV_W-1:0] DEV_LIMIT = DEV_W'(NUM_OSC);

    chan_state_e state_q, state_d;

    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic              start, wsel, sel_ok, go_ok;
    logic [NUM_OSC*32-1:0] osc_flat;
    logic [DATA_W-1:0] osc_rd;

    assign dev    = wdata[DEV_LSB +: DEV_W];
    assign func   = wdata[FUNC_LSB +: FUNC_W];
    assign start  = wdata[START_BIT];
    assign wsel   = wdata[WSEL_BIT];
    assign sel_ok = (func == FUNC_OSC) && (dev < DEV_LIMIT);
    assign go_ok  = ctrl_wr && start && sel_ok;

    // next state: only a control write moves the machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_CLEAR, CH_OK, CH_FAULT: begin
                if (ctrl_wr) begin
                    if (!start)      state_d = CH_CLEAR;
                    else if (sel_ok) state_d = CH_OK;
                    else             state_d = CH_FAULT;
                end
            end
            default: state_d = CH_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_CLEAR;
        else        state_q <= state_d;
    end

    // status decode from state
    always_comb begin
        unique case (state_q)
            CH_CLEAR: stat = 2'b00;
            CH_OK:    stat = 2'b01;
            CH_FAULT: stat = 2'b11;
            default:  stat = 2'b00;
        endcase
    end

    // control and outgoing data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            out_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= wdata & CTRL_KEEP;
            if (out_wr)  out_q  <= wdata;
        end
    end

    // oscillator entries, one register per entry
    for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
        logic [DATA_W-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q <= OSC_RESET[g*32 +: 32];
            else if (go_ok && wsel && (dev == DEV_W'(g)))
                ent_q <= out_q;
        end
        assign osc_flat[g*32 +: 32] = ent_q;
    end

    always_comb begin
        osc_rd = '0;
        for (int i = 0; i < NUM_OSC; i++) begin
            if (dev == DEV_W'(i)) osc_rd = osc_flat[i*32 +: 32];
        end
    end

    // return data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               rtn_q <= '0;
        else if (go_ok && !wsel)  rtn_q <= osc_rd;
    end

endmodule

// File: rtl/board_regs.sv
module board_regs
    import sys_cfg_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                light_wr,
    input  logic [NUM_LEDS-1:0] light_wdata,
    input  logic                lock_wr,
    input  logic [LOOP_N-1:0]   mask_wdata,
    input  logic [LOOP_N-1:0]   lock_status,
    output logic [NUM_LEDS-1:0] light_q,
    output logic [DATA_W-1:0]   lock_word
);

    logic [LOOP_N-1:0] mask_q;
    logic              all_locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            light_q <= '0;
            mask_q  <= '0;
        end else begin
            if (light_wr) light_q <= light_wdata;
            if (lock_wr)  mask_q  <= mask_wdata;
        end
    end

    // loops outside the mask never hold the summary down
    assign all_locked = &(lock_status | ~mask_q);
    assign lock_word  = {mask_q, lock_status, 15'd0, all_locked};

endmodule

// File: rtl/cfg_rdmux.sv
module cfg_rdmux
    import sys_cfg_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_LEDS-1:0] light_q,
    input  logic [DATA_W-1:0]   lock_word,
    input  logic [DATA_W-1:0]   rtn_q,
    input  logic [DATA_W-1:0]   out_q,
    input  logic [DATA_W-1:0]   ctrl_q,
    input  logic [1:0]          stat,
    output logic [DATA_W-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_LIGHT: rdata = DATA_W'(light_q);
            OFF_LOCK:  rdata = lock_word;
            OFF_RTN:   rdata = rtn_q;
            OFF_OUT:   rdata = out_q;
            OFF_CTRL:  rdata = ctrl_q;
            OFF_STAT:  rdata = {30'd0, stat};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/sys_cfg_ctrl.sv
module sys_cfg_ctrl
    import sys_cfg_pkg::*;
#(
    parameter int unsigned           NUM_OSC   = 4,
    parameter int unsigned           NUM_LEDS  = 8,
    parameter logic [NUM_OSC*32-1:0] OSC_RESET = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [11:0]         bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [7:0]          lock_status,
    output logic [NUM_LEDS-1:0] led_out
);

    logic              ctrl_wr, out_wr, light_wr, lock_wr;
    logic [DATA_W-1:0] ctrl_q, out_q, rtn_q, lock_word;
    logic [1:0]        stat_w;

    assign ctrl_wr  = bus_we && (bus_addr == OFF_CTRL);
    assign out_wr   = bus_we && (bus_addr == OFF_OUT);
    assign light_wr = bus_we && (bus_addr == OFF_LIGHT);
    assign lock_wr  = bus_we && (bus_addr == OFF_LOCK);

    cfg_channel #(
        .NUM_OSC   (NUM_OSC),
        .OSC_RESET (OSC_RESET)
    ) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .out_wr  (out_wr),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .out_q   (out_q),
        .rtn_q   (rtn_q),
        .stat    (stat_w)
    );

    board_regs #(
        .NUM_LEDS (NUM_LEDS)
    ) u_board (
        .clk         (clk),
        .rst_n       (rst_n),
        .light_wr    (light_wr),
        .light_wdata (bus_wdata[NUM_LEDS-1:0]),
        .lock_wr     (lock_wr),
        .mask_wdata  (bus_wdata[31:24]),
        .lock_status (lock_status),
        .light_q     (led_out),
        .lock_word   (lock_word)
    );

    cfg_rdmux #(
        .NUM_LEDS (NUM_LEDS)
    ) u_rdmux (
        .addr      (bus_addr),
        .light_q   (led_out),
        .lock_word (lock_word),
        .rtn_q     (rtn_q),
        .out_q     (out_q),
        .ctrl_q    (ctrl_q),
        .stat      (stat_w),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/sys_cfg_ctrl_chk.sv
module sys_cfg_ctrl_chk #(
    parameter int unsigned NUM_OSC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] bus_addr,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [7:0]  lock_status,
    input logic [1:0]  stat_w,
    input logic [31:0] rtn_q
);

    logic ctrl_hit, bad_sel, mapped;
    assign ctrl_hit = bus_we && (bus_addr == 12'h0A8);
    assign bad_sel  = (bus_wdata[25:20] != 6'd1) || (bus_wdata[11:0] >= 12'(NUM_OSC));
    assign mapped   = (bus_addr == 12'h000) || (bus_addr == 12'h004) ||
                      (bus_addr == 12'h0A0) || (bus_addr == 12'h0A4) ||
                      (bus_addr == 12'h0A8) || (bus_addr == 12'h0AC);

    a_r3_plain_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit && !bus_wdata[31] |=> stat_w == 2'b00);

    a_r7_done_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit && bus_wdata[31] |=> stat_w[0]);

    a_r6_bad_sel_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit && bus_wdata[31] && bad_sel |=> stat_w == 2'b11);

    a_r6_bad_sel_keeps_rtn: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit && bus_wdata[31] && bad_sel |=> $stable(rtn_q));

    a_r4_good_sel_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit && bus_wdata[31] && !bad_sel |=> stat_w == 2'b01);

    a_r9_all_locked_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (&lock_status) && bus_addr == 12'h004 |-> bus_rdata[0]);

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == 32'd0);

endmodule

bind sys_cfg_ctrl sys_cfg_ctrl_chk #(.NUM_OSC(NUM_OSC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .lock_status (lock_status),
    .stat_w      (stat_w),
    .rtn_q       (rtn_q)
);

// File: tb/test_sys_cfg_ctrl.sv
module test_sys_cfg_ctrl;

    localparam int unsigned NUM_OSC  = 4;
    localparam int unsigned NUM_LEDS = 8;
    localparam logic [NUM_OSC*32-1:0] OSC_RESET =
        {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [11:0]         bus_addr = '0;
    logic                bus_we = 1'b0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [7:0]          lock_status = 8'hF0;
    logic [NUM_LEDS-1:0] led_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sys_cfg_ctrl #(
        .NUM_OSC   (NUM_OSC),
        .NUM_LEDS  (NUM_LEDS),
        .OSC_RESET (OSC_RESET)
    ) i_sys_cfg_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .lock_status (lock_status),
        .led_out     (led_out)
    );

    typedef struct packed {
        logic [1:0]  op;    // 1 = write, 2 = read and compare
        logic [3:0]  req;
        logic [11:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 4'd8,  12'h000, 32'hFFFF_FFA5},  // R8
        '{2'd2, 4'd8,  12'h000, 32'h0000_00A5},  // R8
        '{2'd1, 4'd9,  12'h004, 32'hF0FF_FFFF},  // R9 mask F0
        '{2'd2, 4'd9,  12'h004, 32'hF0F0_0001},  // R9
        '{2'd1, 4'd9,  12'h004, 32'h0F00_0000},  // R9 mask 0F
        '{2'd2, 4'd9,  12'h004, 32'h0FF0_0000},  // R9
        '{2'd1, 4'd2,  12'h0A8, 32'h7FFF_FFFF},  // R2
        '{2'd2, 4'd2,  12'h0A8, 32'h43F0_0FFF},  // R2
        '{2'd2, 4'd3,  12'h0AC, 32'h0000_0000},  // R3
        '{2'd1, 4'd4,  12'h0A4, 32'hCAFE_0002},  // R4
        '{2'd1, 4'd4,  12'h0A8, 32'hC010_0002},  // R4 write dev 2
        '{2'd2, 4'd4,  12'h0AC, 32'h0000_0001},  // R4
        '{2'd2, 4'd2,  12'h0A8, 32'h4010_0002},  // R2 start dropped
        '{2'd1, 4'd5,  12'h0A8, 32'h8010_0002},  // R5 read dev 2
        '{2'd2, 4'd5,  12'h0AC, 32'h0000_0001},  // R5
        '{2'd2, 4'd5,  12'h0A0, 32'hCAFE_0002},  // R5
        '{2'd1, 4'd5,  12'h0A8, 32'h8010_0000},  // R5 read dev 0
        '{2'd2, 4'd5,  12'h0A0, 32'h1111_0001},  // R5
        '{2'd1, 4'd6,  12'h0A8, 32'h8020_0001},  // R6 function 2
        '{2'd2, 4'd6,  12'h0AC, 32'h0000_0003},  // R6
        '{2'd2, 4'd6,  12'h0A0, 32'h1111_0001},  // R6 rtn kept
        '{2'd1, 4'd6,  12'h0A4, 32'hDEAD_BEEF},  // R6
        '{2'd1, 4'd6,  12'h0A8, 32'hC010_0004},  // R6 device 4 write
        '{2'd2, 4'd6,  12'h0AC, 32'h0000_0003},  // R6
        '{2'd1, 4'd6,  12'h0A8, 32'h8010_0003},  // R6 read dev 3 back
        '{2'd2, 4'd6,  12'h0A0, 32'h4444_0004},  // R6 entry 3 untouched
        '{2'd1, 4'd6,  12'h0A8, 32'h8010_0000},  // R6 read dev 0 back
        '{2'd2, 4'd6,  12'h0A0, 32'h1111_0001},  // R6 entry 0 untouched
        '{2'd1, 4'd3,  12'h0A8, 32'h0010_0000},  // R3
        '{2'd2, 4'd3,  12'h0AC, 32'h0000_0000},  // R3
        '{2'd1, 4'd10, 12'h010, 32'hFFFF_FFFF},  // R10
        '{2'd2, 4'd10, 12'h010, 32'h0000_0000},  // R10
        '{2'd2, 4'd10, 12'h000, 32'h0000_00A5},  // R10
        '{2'd1, 4'd10, 12'h0AC, 32'hFFFF_FFFF},  // R10
        '{2'd2, 4'd10, 12'h0AC, 32'h0000_0000},  // R10
        '{2'd1, 4'd10, 12'h0A0, 32'h0000_0000},  // R10
        '{2'd2, 4'd10, 12'h0A0, 32'h1111_0001},  // R10
        '{2'd2, 4'd10, 12'h0A2, 32'h0000_0000}   // R10 unaligned
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(12'h0A8, v); check("R1 ctrl reset", v, 32'h0010_0000);
        rd(12'h0AC, v); check("R1 status reset", v, 32'h0);
        rd(12'h000, v); check("R1 light reset", v, 32'h0);
        check("R1 led_out reset", 32'(led_out), 32'h0);
        rd(12'h004, v); check("R1 lock reset", v, 32'h00F0_0001);
        wr(12'h0A8, 32'h8010_0001);
        rd(12'h0A0, v); check("R1 osc entry 1 reset", v, 32'h2222_0002);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op == 2'd1) begin
                wr(VEC[i].addr, VEC[i].data);
            end else begin
                @(negedge clk);
                rd(VEC[i].addr, v);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].data);
            end
        end

        // R8 port drive
        check("R8 led_out drive", 32'(led_out), 32'h0000_00A5);

        // R7 result on the read port in the cycle right after the write edge
        wr(12'h0A8, 32'h8010_0003);
        rd(12'h0AC, v); check("R7 status next cycle", v, 32'h1);
        rd(12'h0A0, v); check("R7 return next cycle", v, 32'h4444_0004);

        // R9 live lock inputs with mask 0F
        lock_status = 8'h0F;
        rd(12'h004, v); check("R9 masked loops locked", v, 32'h0F0F_0001);
        lock_status = 8'h07;
        rd(12'h004, v); check("R9 one masked loop unlocked", v, 32'h0F07_0000);
        wr(12'h004, 32'h0000_FFFF);
        rd(12'h004, v); check("R9 empty mask", v, 32'h0007_0001);

        // R6 device index far out of range, then valid write still works (R4)
        wr(12'h0A4, 32'h5555_AAAA);
        wr(12'h0A8, 32'hC010_0800);
        rd(12'h0AC, v); check("R6 device 0x800", v, 32'h3);
        wr(12'h0A8, 32'hC010_0001);
        rd(12'h0AC, v); check("R4 status ok", v, 32'h1);
        wr(12'h0A8, 32'h8010_0001);
        rd(12'h0A0, v); check("R4 entry 1 written", v, 32'h5555_AAAA);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule